// File: doc/BRIEF.md
# Dual-Bank GPIO Controller with Edge Interrupts

This block is a register-mapped general-purpose I/O controller for up to 64 pins. The pins are split into a low bank (pins 0 to 31) and a high bank (pins 32 to 63), and every per-pin control is held as one 32-bit word per bank. Software sets each pin's direction and output level, reads back the synchronised pad level, and arms per-pin edge interrupts.

Each pin watches for a single edge. Its polarity bit picks rising or falling. A detected edge sets a sticky status bit, which software clears by writing ones. Catching both edges means software flips the polarity bit after each event. Two single-bit outputs summarise the state: an interrupt line, raised when any status bit has its enable set, and a wake line, raised when any status bit has its wake bit set. Status itself is stored raw, whatever the enables say.

The host side is a plain word-wide register port with a write strobe. Read data comes back registered, one clock after the address is presented. Pad inputs pass through a synchroniser chain before they are used.

Top module: `gpio_dual_bank`

## Requirements
- R1: After synchronous reset every register reads 0, so all pins are inputs, all polarities select rising edges, and all interrupts and wakes are off. The pad_oe, irq and wake outputs are 0.
- R2: Direction bit 1 makes a pin an output, and pad_oe follows the direction register. pad_out of a pin equals its output-value bit AND its direction bit. Both registers read back what was written.
- R3: The level register returns the pad inputs after a SYNC_STAGES-flop synchroniser. Pin n is found in bank n/32 at bit n%32, and writes to the level register have no effect.
- R4: With polarity bit 0, a synchronised 0-to-1 change on a pin sets its status bit.
- R5: With polarity bit 1, a 1-to-0 change sets the status bit, and a 0-to-1 change leaves it clear.
- R6: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged.
- R7: If an edge is detected in the same cycle that software writes 1 to clear that bit, the bit stays set.
- R8: irq is a register that goes to 1 one clock after any pin has both its status bit and its interrupt-enable bit set. It returns to 0 one clock after no such pin remains.
- R9: wake is a register that goes to 1 one clock after any pin has both its status bit and its wake bit set.
- R10: Register bits for pins at or above NUM_PINS read as 0, even after ones are written to them.
- R11: bus_addr[5] selects the window: 0 is the pin window and 1 is the interrupt window. bus_addr[4:3] selects the register and bus_addr[2] selects the bank (0 low, 1 high). In the pin window, slot 0 is direction, slot 2 is level and slot 3 is output value. In the interrupt window, slot 0 is enable, slot 1 is polarity, slot 2 is status and slot 3 is wake.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe for the addressed word |
| bus_addr | input | 6 | Word address (window, slot, bank) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for the address of the previous cycle |
| pad_in | input | NUM_PINS | Asynchronous pad levels |
| pad_oe | output | NUM_PINS | Per-pin output enable |
| pad_out | output | NUM_PINS | Per-pin driven level, gated by output enable |
| irq | output | 1 | Combined enabled-status interrupt |
| wake | output | 1 | Combined wake-enabled status |

## Verification
The assertions assume that pad_in changes only away from the clock edge, and that a write to the status word is the only way a status bit gets cleared. The bench drives pad levels and bus writes at the falling clock edge. It toggles one pin at a time, so the expected status word depends only on that pin and its polarity. Before a new edge test, it waits until the synchroniser and edge stage have settled. The single collision test is the exception. There, a clearing write is placed exactly in the cycle where the edge is detected, to exercise the set-wins rule.

// File: rtl/gpio_db_pkg.sv
package gpio_db_pkg;
  // register slots, selected by bus_addr[4:3]
  localparam logic [1:0] SLOT_DIR = 2'd0;
  localparam logic [1:0] SLOT_LVL = 2'd2;
  localparam logic [1:0] SLOT_DRV = 2'd3;
  localparam logic [1:0] SLOT_ENA = 2'd0;
  localparam logic [1:0] SLOT_POL = 2'd1;
  localparam logic [1:0] SLOT_STS = 2'd2;
  localparam logic [1:0] SLOT_WAK = 2'd3;

  // replace one 32-bit bank word of a 64-bit pin vector
  function automatic logic [63:0] put_word(logic [63:0] cur, logic hi, logic [31:0] d);
    return hi ? {d, cur[31:0]} : {cur[63:32], d};
  endfunction

  // extract one 32-bit bank word of a 64-bit pin vector
  function automatic logic [31:0] get_word(logic [63:0] v, logic hi);
    return hi ? v[63:32] : v[31:0];
  endfunction
endpackage

// File: rtl/gpio_db_sync.sv
module gpio_db_sync #(
  parameter int W      = 36,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) stg <= '0;
    else     stg <= {stg[STAGES-2:0], d};
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_db_edge.sv
module gpio_db_edge #(
  parameter int W = 36
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] pol,
  input  logic [W-1:0] clr,
  output logic [W-1:0] evt,
  output logic [W-1:0] sts
);
  logic [W-1:0] prev;

  // rising when pol is 0, falling when pol is 1
  assign evt = (lvl & ~prev & ~pol) | (~lvl & prev & pol);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev <= '0;
      sts  <= '0;
    end else begin
      prev <= lvl;
      sts  <= (sts & ~clr) | evt;   // a new edge wins over a clear
    end
  end
endmodule

// File: rtl/gpio_dual_bank.sv
module gpio_dual_bank #(
  parameter int NUM_PINS    = 36,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_we,
  input  logic [5:0]          bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  input  logic [NUM_PINS-1:0] pad_in,
  output logic [NUM_PINS-1:0] pad_oe,
  output logic [NUM_PINS-1:0] pad_out,
  output logic                irq,
  output logic                wake
);
  import gpio_db_pkg::*;

  localparam logic [64:0] ONE65 = 65'd1;
  localparam logic [63:0] VMASK = 64'((ONE65 << NUM_PINS) - ONE65);

  logic [63:0] dir_q, drv_q, ien_q, pol_q, wak_q;
  logic [63:0] lvl64, sts64, clr64, rsel;
  logic [NUM_PINS-1:0] lvl_w, sts_w, evt_w;
  logic        win, hi;
  logic [1:0]  slot;

  assign win  = bus_addr[5];
  assign slot = bus_addr[4:3];
  assign hi   = bus_addr[2];

  gpio_db_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(pad_in), .q(lvl_w)
  );

  gpio_db_edge #(.W(NUM_PINS)) u_edge (
    .clk(clk), .rst(rst), .lvl(lvl_w), .pol(pol_q[NUM_PINS-1:0]),
    .clr(clr64[NUM_PINS-1:0]), .evt(evt_w), .sts(sts_w)
  );

  always_comb begin
    lvl64 = '0;
    sts64 = '0;
    lvl64[NUM_PINS-1:0] = lvl_w;
    sts64[NUM_PINS-1:0] = sts_w;
  end

  always_comb begin
    clr64 = '0;
    if (bus_we && win && slot == SLOT_STS)
      clr64 = put_word(64'd0, hi, bus_wdata) & VMASK;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q <= '0;
      drv_q <= '0;
      ien_q <= '0;
      pol_q <= '0;
      wak_q <= '0;
    end else if (bus_we) begin
      if (!win) begin
        case (slot)
          SLOT_DIR: dir_q <= put_word(dir_q, hi, bus_wdata) & VMASK;
          SLOT_DRV: drv_q <= put_word(drv_q, hi, bus_wdata) & VMASK;
          default: ;
        endcase
      end else begin
        case (slot)
          SLOT_ENA: ien_q <= put_word(ien_q, hi, bus_wdata) & VMASK;
          SLOT_POL: pol_q <= put_word(pol_q, hi, bus_wdata) & VMASK;
          SLOT_WAK: wak_q <= put_word(wak_q, hi, bus_wdata) & VMASK;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rsel = '0;
    if (!win) begin
      case (slot)
        SLOT_DIR: rsel = dir_q;
        SLOT_LVL: rsel = lvl64;
        SLOT_DRV: rsel = drv_q;
        default:  rsel = '0;
      endcase
    end else begin
      case (slot)
        SLOT_ENA: rsel = ien_q;
        SLOT_POL: rsel = pol_q;
        SLOT_STS: rsel = sts64;
        default:  rsel = wak_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq       <= 1'b0;
      wake      <= 1'b0;
    end else begin
      bus_rdata <= get_word(rsel, hi);
      irq       <= |(sts64 & ien_q);
      wake      <= |(sts64 & wak_q);
    end
  end

  assign pad_oe  = dir_q[NUM_PINS-1:0];
  assign pad_out = drv_q[NUM_PINS-1:0] & dir_q[NUM_PINS-1:0];
endmodule

// File: rtl/gpio_dual_bank_chk.sv
module gpio_dual_bank_chk #(
  parameter int NUM_PINS = 36
) (
  input logic                clk,
  input logic                rst,
  input logic                bus_we,
  input logic [5:0]          bus_addr,
  input logic [31:0]         bus_wdata,
  input logic [NUM_PINS-1:0] pad_oe,
  input logic                irq,
  input logic                wake,
  input logic [NUM_PINS-1:0] sts,
  input logic [NUM_PINS-1:0] evt,
  input logic [63:0]         ien
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!irq && !wake && pad_oe == '0));

  // R2
  dir_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == 6'h00) |=> (pad_oe[0] == $past(bus_wdata[0])));

  // R6
  sts_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == 6'h30 && bus_wdata[0] && !evt[0]) |=> !sts[0]);

  // R7
  evt_latch_chk: assert property (@(posedge clk) disable iff (rst)
    evt[0] |=> sts[0]);

  // R8
  irq_source_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(|(sts & ien[NUM_PINS-1:0])));
endmodule

bind gpio_dual_bank gpio_dual_bank_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .pad_oe(pad_oe), .irq(irq), .wake(wake),
  .sts(sts_w), .evt(evt_w), .ien(ien_q)
);

// File: tb/gpio_dual_bank_test.sv
module gpio_dual_bank_test;
  localparam int NP = 36;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_we = 1'b0;
  logic [5:0]    bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NP-1:0] pad_in = '0;
  logic [NP-1:0] pad_oe, pad_out;
  logic          irq, wake;

  int vectors = 0;
  int errors  = 0;
  bit done    = 0;

  always #10 clk = ~clk;

  gpio_dual_bank #(.NUM_PINS(NP), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_oe(pad_oe), .pad_out(pad_out), .irq(irq), .wake(wake)
  );

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  endtask

  // expected status for a single toggle to level nv under polarity pol
  function automatic logic edge_hit(logic pol, logic nv);
    return pol ? !nv : nv;
  endfunction

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] r;
    logic [31:0] d0, d1, o0, o1;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset values
    rd(6'h00, r); check("R1 dir", r, 0);
    rd(6'h1C, r); check("R1 drv hi", r, 0);
    rd(6'h20, r); check("R1 ien", r, 0);
    rd(6'h28, r); check("R1 pol", r, 0);
    rd(6'h30, r); check("R1 sts", r, 0);
    rd(6'h3C, r); check("R1 wake reg", r, 0);
    check("R1 pad_oe", pad_oe, 0);
    check("R1 irq/wake", {irq, wake}, 0);

    // R2, R11: directed direction and drive
    wr(6'h00, 32'hA5A5_0F0F);
    wr(6'h18, 32'hFFFF_0000);
    rd(6'h00, r); check("R2 dir readback", r, 32'hA5A5_0F0F);
    rd(6'h18, r); check("R11 drv slot", r, 32'hFFFF_0000);
    check("R2 pad_out gated", pad_out[31:0], 32'hA5A5_0000);
    // R10: high bank limited to 4 pins
    wr(6'h04, 32'hFFFF_FFFF);
    rd(6'h04, r); check("R10 dir hi mask", r, 32'hF);
    wr(6'h2C, 32'hFFFF_FFFF);
    rd(6'h2C, r); check("R10 pol hi mask", r, 32'hF);
    wr(6'h2C, 32'h0);

    // R2: random direction/drive patterns
    for (int i = 0; i < 20; i++) begin
      d0 = $urandom; d1 = $urandom; o0 = $urandom; o1 = $urandom;
      wr(6'h00, d0); wr(6'h04, d1); wr(6'h18, o0); wr(6'h1C, o1);
      @(negedge clk);
      check("R2 pad_oe", pad_oe, {d1[3:0], d0});
      check("R2 pad_out", pad_out, {o1[3:0] & d1[3:0], o0 & d0});
    end
    wr(6'h00, 0); wr(6'h04, 0);

    // R3: synchronised level, bank split, write ignored
    pad_in = 36'h9_1234_5678;
    settle();
    rd(6'h10, r); check("R3 level lo", r, 32'h1234_5678);
    rd(6'h14, r); check("R3 level hi", r, 32'h9);
    wr(6'h10, 32'hFFFF_FFFF);
    rd(6'h10, r); check("R3 level write ignored", r, 32'h1234_5678);
    wr(6'h30, 32'hFFFF_FFFF); wr(6'h34, 32'hFFFF_FFFF);
    rd(6'h30, r); check("R6 clear all", r, 0);

    // R4, R8, R9: pin 33 rising
    wr(6'h24, 32'h2);
    pad_in[33] = 1'b1;
    settle();
    rd(6'h34, r); check("R4 rise pin33", r, 32'h2);
    check("R8 irq set", irq, 1);
    check("R9 wake off", wake, 0);
    wr(6'h3C, 32'h2);
    @(negedge clk);
    check("R9 wake set", wake, 1);
    wr(6'h34, 32'h0);
    rd(6'h34, r); check("R6 zero write keeps", r, 32'h2);
    wr(6'h34, 32'h2);
    rd(6'h34, r); check("R6 one write clears", r, 0);
    check("R8 irq drops", irq, 0);
    check("R9 wake drops", wake, 0);
    wr(6'h3C, 0); wr(6'h24, 0);

    // R5: pin 2 falling only
    wr(6'h28, 32'h4);
    pad_in[2] = 1'b1;
    settle();
    rd(6'h30, r); check("R5 rise ignored", r, 0);
    pad_in[2] = 1'b0;
    settle();
    rd(6'h30, r); check("R5 fall detected", r, 32'h4);
    wr(6'h30, 32'h4);
    wr(6'h28, 32'h0);

    // R7: clear coincides with detection of pin 0 rising edge
    @(negedge clk);
    pad_in[0] = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = 6'h30; bus_wdata = 32'h1;
    @(negedge clk);
    bus_we = 1'b0;
    rd(6'h30, r); check("R7 set wins over clear", r, 32'h1);
    wr(6'h30, 32'h1);
    rd(6'h30, r); check("R6 later clear", r, 0);

    // R4/R5: random single-pin toggles
    for (int i = 0; i < 24; i++) begin
      int p;
      logic pl, nv;
      logic [5:0] base;
      p  = int'($urandom % NP);
      pl = 1'($urandom);
      base = (p >= 32) ? 6'h04 : 6'h00;
      wr(6'h28 | base, 32'(pl) << (p % 32));
      wr(6'h30, 32'hFFFF_FFFF); wr(6'h34, 32'hFFFF_FFFF);
      nv = ~pad_in[p];
      @(negedge clk);
      pad_in[p] = nv;
      settle();
      rd(6'h30 | base, r);
      check(pl ? "R5 random edge" : "R4 random edge", r,
            edge_hit(pl, nv) ? (64'd1 << (p % 32)) : 64'd0);
    end

    finish_run();
  end
endmodule